// File: doc/BRIEF.md
# Peripheral Reference Clock Period Calculator

This block works out the periods of two peripheral reference clocks from one input reference period and a set of control words. There are three PLLs: IO, ARM and DDR. For each one the block turns the input period into a PLL output period using that PLL's control word. One peripheral control word then picks a PLL output, scales it by a divisor, and gates each of the two outputs on its own enable bit. All values are periods, so a PLL multiplier divides the period and a peripheral divisor multiplies it.

The block does not generate any clock. It only computes numbers for the clock model or clock-tree logic around it. A new computation starts on any of these events:

- a recompute strobe,
- the first cycle after reset,
- a change of the input period,
- a change of the reset-hold input.

When a computation starts, the block captures every control word. One serial divider is shared by the three PLL divisions. While a computation runs, the valid flag is low and the outputs keep their last published values. When the flag rises, both outputs are fresh.

Top module: `clkrate_core`

## Requirements
- R1: When bit 4 of a PLL control word is set, that PLL's output equals the input period unchanged. This holds whatever the other bits of the word are.
- R2: When bit 4 is clear and bit 0 or bit 1 of a PLL control word is set, that PLL's output is 0.
- R3: Otherwise the PLL output is the input period divided by the 7-bit multiplier in bits 18:12, with the quotient truncated. A multiplier field of 0 means 128.
- R4: Bits 5:4 of the peripheral control word select the source period: code 0 selects IO, 1 selects IO, 2 selects ARM and 3 selects DDR.
- R5: The 6-bit divisor in bits 13:8 of the peripheral control word multiplies the selected period, with the result taken modulo 2^64. A divisor of 0 acts as 1.
- R6: Output 0 is enabled by bit 0 of the peripheral control word and output 1 by bit 1. A disabled output reports 0.
- R7: While `hold` is high, the input period is taken as 0, so both outputs read 0 once the flag is valid. When `hold` falls, the outputs are recomputed from the real input without a strobe.
- R8: A computation starts on `recalc`, on any change of `ref_period` and on any change of `hold`. The control words are captured only when a computation starts, so a control word changed without a strobe has no effect.
- R9: `valid` is low in the cycle after a start event and rises within 3*PW+8 cycles. While `valid` stays high, both outputs are stable.
- R10: A start event during a running computation restarts it. The flag never rises on a result from before the latest start event.
- R11: Synchronous reset clears both outputs and `valid`. After reset the block computes once without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Reset-hold: treat the input period as zero |
| recalc | input | 1 | Recompute strobe, one cycle |
| ref_period | input | PW | Input reference period |
| pll_io_ctrl | input | CTRL_W | IO PLL control word |
| pll_arm_ctrl | input | CTRL_W | ARM PLL control word |
| pll_ddr_ctrl | input | CTRL_W | DDR PLL control word |
| per_ctrl | input | CTRL_W | Peripheral clock control word (select, divisor, enables) |
| ref0_period | output | PW | Period of peripheral reference clock 0 |
| ref1_period | output | PW | Period of peripheral reference clock 1 |
| valid | output | 1 | Both outputs are up to date |

## Verification
A recompute strobe can land in the same cycle as a divider completion or as the final output update. In that case the restart must win, and the finished but stale result must not be published.

The bench provokes this by starting one computation and then issuing a second strobe with a new configuration. It sweeps the gap between the two strobes across the whole length of a computation, in small steps. In every case the outputs must match the second configuration once the flag rises. A checker also flags any rise of `valid` in the cycle right after a strobe.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;
  // PLL control word fields
  localparam int PLL_RST_BIT = 0;
  localparam int PLL_PD_BIT  = 1;
  localparam int PLL_BYP_BIT = 4;
  localparam int MULT_LSB    = 12;
  localparam int MULT_W      = 7;
  // peripheral control word fields
  localparam int SEL_LSB     = 4;
  localparam int DIV_LSB     = 8;
  localparam int DIV_W       = 6;
  localparam int NUM_PLL     = 3;   // 0 = IO, 1 = ARM, 2 = DDR
  localparam int NUM_OUT     = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_OUT} seq_t;
endpackage

// File: rtl/clkrate_div.sv
// Restoring serial divider, one quotient bit per cycle.
module clkrate_div #(
  parameter int W  = 64,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic [W-1:0]  quotient,
  output logic          done
);
  localparam int CNTW = $clog2(W + 1);

  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   rem;
  logic [DW-1:0]   dvs;
  logic            busy;
  logic [DW:0]     trial;
  logic            fits;

  assign trial    = {rem, quotient[W-1]};
  assign fits     = (trial >= {1'b0, dvs});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rem      <= '0;
      dvs      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quotient <= dividend;
        dvs      <= divisor;
        rem      <= '0;
        cnt      <= CNTW'(W);
        busy     <= 1'b1;
      end else if (busy) begin
        rem      <= fits ? DW'(trial - {1'b0, dvs}) : trial[DW-1:0];
        quotient <= {quotient[W-2:0], fits};
        cnt      <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clkrate_pll.sv
// Applies the PLL override bits to a divided period.
module clkrate_pll #(
  parameter int PW     = 64,
  parameter int CTRL_W = 32
) (
  input  logic [PW-1:0]     src,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [PW-1:0]     quot,
  output logic [PW-1:0]     out
);
  import clkrate_pkg::*;

  always_comb begin
    if (ctrl[PLL_BYP_BIT])
      out = src;
    else if (ctrl[PLL_RST_BIT] || ctrl[PLL_PD_BIT])
      out = '0;
    else
      out = quot;
  end
endmodule

// File: rtl/clkrate_tap.sv
// Source select, divisor scaling and gating for one peripheral output.
module clkrate_tap #(
  parameter int PW     = 64,
  parameter int CTRL_W = 32,
  parameter int EN_BIT = 0
) (
  input  logic [PW-1:0]     io_p,
  input  logic [PW-1:0]     arm_p,
  input  logic [PW-1:0]     ddr_p,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [PW-1:0]     out
);
  import clkrate_pkg::*;

  logic [1:0]       sel;
  logic [DIV_W-1:0] dv;
  logic [PW-1:0]    dv_eff;
  logic [PW-1:0]    pick;

  assign sel    = ctrl[SEL_LSB +: 2];
  assign dv     = ctrl[DIV_LSB +: DIV_W];
  assign dv_eff = (dv == '0) ? PW'(1) : PW'(dv);

  always_comb begin
    case (sel)
      2'd2:    pick = arm_p;
      2'd3:    pick = ddr_p;
      default: pick = io_p;
    endcase
  end

  assign out = ctrl[EN_BIT] ? pick * dv_eff : '0;
endmodule

// File: rtl/clkrate_core.sv
module clkrate_core #(
  parameter int PW     = 64,
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              recalc,
  input  logic [PW-1:0]     ref_period,
  input  logic [CTRL_W-1:0] pll_io_ctrl,
  input  logic [CTRL_W-1:0] pll_arm_ctrl,
  input  logic [CTRL_W-1:0] pll_ddr_ctrl,
  input  logic [CTRL_W-1:0] per_ctrl,
  output logic [PW-1:0]     ref0_period,
  output logic [PW-1:0]     ref1_period,
  output logic              valid
);
  import clkrate_pkg::*;

  localparam int DVW = MULT_W + 1;

  seq_t              state;
  logic [1:0]        idx;
  logic              kick;
  logic [PW-1:0]     last_ref;
  logic              last_hold;
  logic [PW-1:0]     src_q;
  logic [CTRL_W-1:0] pctl_q [NUM_PLL];
  logic [CTRL_W-1:0] per_q;
  logic [PW-1:0]     quot_q [NUM_PLL];
  logic [PW-1:0]     pll_p  [NUM_PLL];
  logic [PW-1:0]     tap_p  [NUM_OUT];
  logic              trigger;
  logic [MULT_W-1:0] mfield;
  logic [DVW-1:0]    div_by;
  logic [PW-1:0]     div_q;
  logic              div_done;

  assign trigger = kick | recalc | (ref_period != last_ref) | (hold != last_hold);
  assign mfield  = pctl_q[idx][MULT_LSB +: MULT_W];
  assign div_by  = (mfield == '0) ? DVW'(1 << MULT_W) : DVW'(mfield);

  clkrate_div #(.W(PW), .DW(DVW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (state == ST_LOAD),
    .dividend (src_q),
    .divisor  (div_by),
    .quotient (div_q),
    .done     (div_done)
  );

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    clkrate_pll #(.PW(PW), .CTRL_W(CTRL_W)) u_pll (
      .src  (src_q),
      .ctrl (pctl_q[g]),
      .quot (quot_q[g]),
      .out  (pll_p[g])
    );
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_tap
    clkrate_tap #(.PW(PW), .CTRL_W(CTRL_W), .EN_BIT(g)) u_tap (
      .io_p  (pll_p[0]),
      .arm_p (pll_p[1]),
      .ddr_p (pll_p[2]),
      .ctrl  (per_q),
      .out   (tap_p[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      kick        <= 1'b1;
      last_ref    <= '0;
      last_hold   <= 1'b0;
      src_q       <= '0;
      per_q       <= '0;
      ref0_period <= '0;
      ref1_period <= '0;
      valid       <= 1'b0;
      for (int i = 0; i < NUM_PLL; i++) begin
        pctl_q[i] <= '0;
        quot_q[i] <= '0;
      end
    end else begin
      kick <= 1'b0;
      if (trigger) begin
        last_ref  <= ref_period;
        last_hold <= hold;
        src_q     <= hold ? '0 : ref_period;
        pctl_q[0] <= pll_io_ctrl;
        pctl_q[1] <= pll_arm_ctrl;
        pctl_q[2] <= pll_ddr_ctrl;
        per_q     <= per_ctrl;
        idx       <= '0;
        valid     <= 1'b0;
        state     <= ST_LOAD;
      end else begin
        case (state)
          ST_LOAD: state <= ST_WAIT;
          ST_WAIT: if (div_done) begin
            quot_q[idx] <= div_q;
            if (idx == 2'(NUM_PLL - 1)) begin
              state <= ST_OUT;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_LOAD;
            end
          end
          ST_OUT: begin
            ref0_period <= tap_p[0];
            ref1_period <= tap_p[1];
            valid       <= 1'b1;
            state       <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkrate_core_chk.sv
module clkrate_core_chk #(
  parameter int PW     = 64,
  parameter int CTRL_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              recalc,
  input logic              valid,
  input logic [PW-1:0]     ref0_period,
  input logic [PW-1:0]     ref1_period,
  input logic [CTRL_W-1:0] per_q
);
  assert_valid_clear_R9: assert property (@(posedge clk) disable iff (rst)
    recalc |=> !valid);

  assert_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> ($stable(ref0_period) && $stable(ref1_period)));

  assert_no_stale_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> !$past(recalc));

  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && hold && $past(hold)) |-> (ref0_period == '0 && ref1_period == '0));

  assert_gate0_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !per_q[0]) |-> (ref0_period == '0));

  assert_gate1_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !per_q[1]) |-> (ref1_period == '0));
endmodule

bind clkrate_core clkrate_core_chk #(.PW(PW), .CTRL_W(CTRL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hold        (hold),
  .recalc      (recalc),
  .valid       (valid),
  .ref0_period (ref0_period),
  .ref1_period (ref1_period),
  .per_q       (per_q)
);

// File: tb/sim_clkrate_core.sv
`timescale 1ns/1ps
module sim_clkrate_core;
  localparam int LIM = 3 * 64 + 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold = 1'b0;
  logic        recalc = 1'b0;
  logic [63:0] r_ref = 64'd1_000_003;
  logic [31:0] r_io = 32'h0000_3000;
  logic [31:0] r_arm = 32'h0000_5000;
  logic [31:0] r_ddr = 32'h0000_0000;
  logic [31:0] r_per = 32'h0000_0103;
  logic [63:0] p0, p1;
  logic        valid;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  clkrate_core u0 (
    .clk (clk), .rst (rst), .hold (hold), .recalc (recalc),
    .ref_period (r_ref), .pll_io_ctrl (r_io), .pll_arm_ctrl (r_arm),
    .pll_ddr_ctrl (r_ddr), .per_ctrl (r_per),
    .ref0_period (p0), .ref1_period (p1), .valid (valid)
  );

  function automatic logic [63:0] e_pll(input logic [63:0] in, input logic [31:0] c);
    logic [63:0] m;
    if (c[4]) return in;
    if (c[0] || c[1]) return 64'd0;
    m = {57'd0, c[18:12]};
    if (m == 0) m = 64'd128;
    return in / m;
  endfunction

  function automatic logic [63:0] e_out(input int k, input logic [63:0] in,
      input logic [31:0] io, input logic [31:0] arm, input logic [31:0] ddr,
      input logic [31:0] per);
    logic [63:0] s, d;
    if (!per[k]) return 64'd0;
    case (per[5:4])
      2'd2: s = e_pll(in, arm);
      2'd3: s = e_pll(in, ddr);
      default: s = e_pll(in, io);
    endcase
    d = {58'd0, per[13:8]};
    if (d == 0) d = 64'd1;
    return s * d;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag, input logic [63:0] in);
    check64(tag, p0, e_out(0, in, r_io, r_arm, r_ddr, r_per));
    check64(tag, p1, e_out(1, in, r_io, r_arm, r_ddr, r_per));
  endtask

  task automatic wait_valid(input string tag);
    int n = 0;
    while (!valid && n < LIM) begin
      @(negedge clk);
      n++;
    end
    if (!valid) check64({tag, " valid timeout"}, 64'(valid), 64'd1);
  endtask

  // strobe, confirm valid dropped, wait for result
  task automatic go(input string tag);
    recalc = 1'b1;
    @(negedge clk);
    recalc = 1'b0;
    check64("R9 valid drop", 64'(valid), 64'd0);
    wait_valid(tag);
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R11: reset state
    check64("R11 reset out0", p0, 64'd0);
    check64("R11 reset out1", p1, 64'd0);
    check64("R11 reset valid", 64'(valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    wait_valid("R11");
    check_outs("R11 auto compute", r_ref);

    // R1 R2 R3: flag combinations and multipliers on the IO PLL
    r_ref = 64'd1_000_003;
    r_per = 32'h0000_0103;
    for (int f = 0; f < 8; f++) begin
      for (int mi = 0; mi < 4; mi++) begin
        logic [6:0] m;
        string t;
        m = (mi == 0) ? 7'd0 : (mi == 1) ? 7'd1 : (mi == 2) ? 7'd5 : 7'd127;
        @(negedge clk);
        r_io = {13'd0, m, 7'd0, f[2], 2'b00, f[1], f[0]};
        t = f[2] ? "R1" : (f[1:0] != 0) ? "R2" : "R3";
        go(t);
        check_outs(t, r_ref);
      end
    end

    // R4 R5 R6: select, divisor and enables
    r_ref = 64'hF123_4567_89AB_CDEF;
    r_io  = 32'h0000_3000;
    r_arm = 32'h0000_0000;
    r_ddr = 32'h0000_7013;
    for (int s = 0; s < 4; s++) begin
      for (int di = 0; di < 4; di++) begin
        for (int e = 0; e < 4; e++) begin
          logic [5:0] dv;
          string t;
          dv = (di == 0) ? 6'd0 : (di == 1) ? 6'd1 : (di == 2) ? 6'd2 : 6'd63;
          @(negedge clk);
          r_per = {18'd0, dv, 2'b00, s[1:0], 2'b00, e[1:0]};
          t = (e != 3) ? "R6" : (di != 2) ? "R5" : "R4";
          go(t);
          check_outs(t, r_ref);
        end
      end
    end

    // R7: hold forces zero, release recomputes without strobe
    r_ref = 64'd777_777;
    r_io  = 32'h0000_4000;
    r_per = 32'h0000_0203;
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    check64("R7 hold drop", 64'(valid), 64'd0);
    wait_valid("R7");
    check64("R7 hold out0", p0, 64'd0);
    check64("R7 hold out1", p1, 64'd0);
    hold = 1'b0;
    @(negedge clk);
    check64("R7 release drop", 64'(valid), 64'd0);
    wait_valid("R7");
    check_outs("R7 release", r_ref);

    // R8: input change triggers; control change alone is ignored
    r_ref = 64'd123_456_789;
    @(negedge clk);
    check64("R8 ref change drop", 64'(valid), 64'd0);
    wait_valid("R8");
    check_outs("R8 ref change", r_ref);
    begin
      logic [63:0] o0, o1;
      o0 = p0;
      o1 = p1;
      r_per = 32'h0000_3F23;
      repeat (30) @(negedge clk);
      check64("R8 ignored valid", 64'(valid), 64'd1);
      check64("R8 ignored out0", p0, o0);
      check64("R8 ignored out1", p1, o1);
      check64("R9 stable out0", p0, o0);
    end
    go("R8");
    check_outs("R8 after strobe", r_ref);

    // R10: second strobe swept across the running computation
    for (int off = 1; off <= 3 * 64 + 12; off += 5) begin
      @(negedge clk);
      r_ref = 64'd50_000 + 64'(off);
      r_io  = 32'h0000_2000;
      r_per = 32'h0000_0403;
      recalc = 1'b1;
      @(negedge clk);
      recalc = 1'b0;
      repeat (off - 1) @(negedge clk);
      r_ref = 64'd9_000_001 + 64'(off);
      r_io  = 32'h0000_9000;
      r_arm = 32'h0000_3000;
      r_per = 32'h0000_0523;
      go("R10");
      check_outs("R10 restart", r_ref);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule